// File: doc/BRIEF.md
# Common-Start Timeout Hit Filter

This block sits on the stream of raw time measurements coming out of a common-start time-to-digital converter. Each hit carries a raw count whose weight is set by the converter's resolution. A timeout is programmed in coarse 8 ns units. The block scales that timeout into raw counts for the selected resolution. Any hit whose raw time is at or above the scaled value is discarded. Hits below it are forwarded one clock later.

The block also checks whether the programmed timeout can be represented for the current resolution and edge mode. If it cannot, it raises a configuration-error flag, but filtering carries on with the scaled value. A saturating counter records how many hits were discarded. Software or a sequencer can clear that counter with a synchronous clear input.

Top module: `cs_timeout_filter`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid_o` is 0 and `drop_count_o` is 0.
- R2: A hit with `hit_valid_i`=1 and raw time strictly below the scaled threshold appears on `out_time_o` with `out_valid_o`=1 on the following clock cycle, with the time value unchanged; back-to-back hits keep their order.
- R3: A hit whose raw time is greater than or equal to the scaled threshold produces no `out_valid_o`; a time exactly equal to the threshold is dropped.
- R4: The scaled threshold equals `tmo_field_i` multiplied by 16, 8, 4 or 2 when `res_sel_i` is 0, 1, 2 or 3 (0.5, 1, 2 or 4 ns per raw count).
- R5: With `both_edges_i`=0, `cfg_error_o` is 1 exactly when the scaled threshold is at or above 1024, 2048, 4096 or 8192 for `res_sel_i` = 0, 1, 2 or 3; the flag follows the configuration inputs combinationally.
- R6: With `both_edges_i`=1, each of those limits is halved (512, 1024, 2048, 4096).
- R7: While `cfg_error_o` is 1, hits are still filtered against the scaled threshold.
- R8: `drop_count_o` increases by one for each dropped hit and holds at 65535 once it gets there.
- R9: `drop_clr_i`=1 sets `drop_count_o` to 0 on the next clock edge; a hit dropped on that same cycle is not counted.
- R10: A cycle with `hit_valid_i`=0 produces no `out_valid_o` and leaves `drop_count_o` unchanged, whatever `hit_time_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_time_i | input | 16 | Raw measured time of the incoming hit |
| hit_valid_i | input | 1 | Incoming hit strobe |
| tmo_field_i | input | 12 | Timeout in 8 ns units |
| res_sel_i | input | 2 | Resolution select: 0=0.5 ns, 1=1 ns, 2=2 ns, 3=4 ns |
| both_edges_i | input | 1 | 1 when both edges are recorded, 0 for leading edge only |
| drop_clr_i | input | 1 | Synchronous clear of the drop counter |
| out_time_o | output | 16 | Raw time of the forwarded hit |
| out_valid_o | output | 1 | Forwarded hit strobe |
| drop_count_o | output | 16 | Saturating count of dropped hits |
| cfg_error_o | output | 1 | Scaled timeout is not below the allowed maximum |

## Verification
The hardest state to reach from the ports is counter saturation: 65535 hits must be dropped before the hold at the top can be observed. The stimulus selects the smallest nonzero threshold (field 1 at 4 ns, which is 2 raw counts). It then streams late hits back to back, a few past the saturation point, and checks that the count stays at 65535. The configuration-error boundaries are swept for every resolution and edge mode, each one just below and exactly at its limit.

// File: rtl/cs_timeout_filter.sv
module cs_timeout_filter #(
  parameter int TIME_W = 16,
  parameter int TMO_W  = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] hit_time_i,
  input  logic              hit_valid_i,
  input  logic [TMO_W-1:0]  tmo_field_i,
  input  logic [1:0]        res_sel_i,
  input  logic              both_edges_i,
  input  logic              drop_clr_i,
  output logic [TIME_W-1:0] out_time_o,
  output logic              out_valid_o,
  output logic [CNT_W-1:0]  drop_count_o,
  output logic              cfg_error_o
);
  localparam int THR_W = TMO_W + 4;
  localparam int MW0   = (TIME_W > THR_W) ? TIME_W : THR_W;
  localparam int CMP_W = (MW0 > 14) ? MW0 : 14;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [THR_W-1:0] thr_raw;
  logic [CMP_W-1:0] thr_w, time_w, lim_w;
  logic             pass, drop;

  always_comb begin
    case (res_sel_i)
      2'd0:    thr_raw = {tmo_field_i, 4'b0};
      2'd1:    thr_raw = {1'b0, tmo_field_i, 3'b0};
      2'd2:    thr_raw = {2'b0, tmo_field_i, 2'b0};
      default: thr_raw = {3'b0, tmo_field_i, 1'b0};
    endcase
  end

  assign thr_w  = CMP_W'(thr_raw);
  assign time_w = CMP_W'(hit_time_i);
  assign lim_w  = (CMP_W'(14'd1024) << res_sel_i) >> both_edges_i;

  assign cfg_error_o = thr_w >= lim_w;
  assign pass        = time_w < thr_w;
  assign drop        = hit_valid_i && !pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_time_o  <= '0;
    end else begin
      out_valid_o <= hit_valid_i && pass;
      if (hit_valid_i && pass) out_time_o <= hit_time_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           drop_count_o <= '0;
    else if (drop_clr_i)                  drop_count_o <= '0;
    else if (drop && drop_count_o != CNT_MAX) drop_count_o <= drop_count_o + 1'b1;
  end

  // Limit restated in timeout units: field >= 2^(6 + 2*res - both)
  logic [TMO_W:0] unit_lim;
  assign unit_lim = (TMO_W+1)'(1) << (4'd6 + {1'b0, res_sel_i, 1'b0} - {3'b0, both_edges_i});

  assert_cfg_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error_o == ({1'b0, tmo_field_i} >= unit_lim));

  assert_valid_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && out_valid_o |-> $past(hit_valid_i));

  assert_data_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && out_valid_o |-> out_time_o == $past(hit_time_i));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(drop_clr_i) |-> drop_count_o == '0);

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(drop_clr_i) |-> drop_count_o >= $past(drop_count_o));

  assert_hold_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(drop_clr_i) && $past(drop_count_o) == CNT_MAX |-> drop_count_o == CNT_MAX);

  assert_idle_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(drop_clr_i) && !$past(hit_valid_i) |-> $stable(drop_count_o));
endmodule

// File: tb/cs_timeout_filter_tb_top.sv
module cs_timeout_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hit_time_i = '0;
  logic        hit_valid_i = 1'b0;
  logic [11:0] tmo_field_i = '0;
  logic [1:0]  res_sel_i = '0;
  logic        both_edges_i = 1'b0;
  logic        drop_clr_i = 1'b0;
  logic [15:0] out_time_o;
  logic        out_valid_o;
  logic [15:0] drop_count_o;
  logic        cfg_error_o;

  cs_timeout_filter dut_i (
    .clk(clk), .rst_n(rst_n), .hit_time_i(hit_time_i), .hit_valid_i(hit_valid_i),
    .tmo_field_i(tmo_field_i), .res_sel_i(res_sel_i), .both_edges_i(both_edges_i),
    .drop_clr_i(drop_clr_i), .out_time_o(out_time_o), .out_valid_o(out_valid_o),
    .drop_count_o(drop_count_o), .cfg_error_o(cfg_error_o));

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  logic [15:0] sb_q[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int thr_of(input int fld, input int res);
    return fld * (16 >> res);
  endfunction

  // driver: one hit per call, applied at a falling edge
  task automatic send(input int t);
    @(negedge clk);
    hit_time_i  = 16'(t);
    hit_valid_i = 1'b1;
    if (t < thr_of(int'(tmo_field_i), int'(res_sel_i))) sb_q.push_back(16'(t));
    else if (exp_cnt < 65535) exp_cnt++;
  endtask

  task automatic idle(input int n, input int junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hit_valid_i = 1'b0;
      hit_time_i  = 16'(junk);
    end
  endtask

  task automatic cfg(input int fld, input int res, input bit both);
    @(negedge clk);
    hit_valid_i  = 1'b0;
    tmo_field_i  = 12'(fld);
    res_sel_i    = 2'(res);
    both_edges_i = both;
  endtask

  task automatic chk_cfg(input int fld, input int res, input bit both);
    int lim;
    bit ex;
    cfg(fld, res, both);
    #1;
    lim = (1024 << res) >> both;
    ex  = thr_of(fld, res) >= lim;
    check(cfg_error_o == ex, both ? "R6 cfg_error" : "R5 cfg_error", int'(cfg_error_o), int'(ex));
  endtask

  task automatic chk_count(input string req);
    idle(2, 0);
    check(int'(drop_count_o) == exp_cnt, req, int'(drop_count_o), exp_cnt);
  endtask

  // monitor: pop and compare every forwarded hit (R2, R3, R10)
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (sb_q.size() == 0) check(0, "R3/R10 unexpected out_valid", int'(out_time_o), -1);
      else begin
        logic [15:0] e;
        e = sb_q.pop_front();
        check(out_time_o == e, "R2 forwarded time", int'(out_time_o), int'(e));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0, "R1 valid in reset", int'(out_valid_o), 0);
    check(drop_count_o == 16'd0, "R1 count in reset", int'(drop_count_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0, "R1 valid after reset", int'(out_valid_o), 0);
    check(drop_count_o == 16'd0, "R1 count after reset", int'(drop_count_o), 0);

    // R4 scaling per resolution, at the threshold edge: thr-1 passes, thr drops
    for (int r = 0; r < 4; r++) begin
      cfg(50, r, 1'b0);
      send(thr_of(50, r) - 1);
      send(thr_of(50, r));
      send(0);
      idle(1, 0);
    end
    chk_count("R4/R3 drops at threshold");

    // R2 back-to-back stream, R3 mixed
    cfg(63, 0, 1'b0);  // threshold 1008
    for (int i = 0; i < 20; i++) send((i * 97) % 1100);
    idle(2, 0);
    chk_count("R3 mixed stream drops");
    check(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);

    // R10 idle cycles with garbage time
    idle(6, 16'hFFFF);
    chk_count("R10 idle no count");

    // R5/R6 limit boundaries
    for (int r = 0; r < 4; r++) begin
      for (int b = 0; b < 2; b++) begin
        int lf;
        lf = ((1024 << r) >> b) / thr_of(1, r);
        if (lf <= 4095) begin
          chk_cfg(lf - 1, r, b[0]);
          chk_cfg(lf, r, b[0]);
        end else chk_cfg(4095, r, b[0]);
      end
    end

    // R7 error config still filters
    cfg(100, 0, 1'b1);  // threshold 1600, error
    #1 check(cfg_error_o == 1'b1, "R7 error set", int'(cfg_error_o), 1);
    send(1599);
    send(1600);
    send(40000);
    idle(2, 0);
    chk_count("R7 drops under error");

    // R9 clear, with a simultaneous drop not counted
    @(negedge clk);
    drop_clr_i  = 1'b1;
    hit_valid_i = 1'b1;
    hit_time_i  = 16'd60000;
    @(negedge clk);
    drop_clr_i  = 1'b0;
    hit_valid_i = 1'b0;
    exp_cnt = 0;
    chk_count("R9 clear wins");
    send(2000);
    chk_count("R8 count after clear");

    // R8 saturation
    cfg(1, 3, 1'b0);  // threshold 2
    for (int i = 0; i < 65540; i++) send(5);
    chk_count("R8 saturates");
    send(9);
    chk_count("R8 holds at max");
    send(1);
    idle(2, 0);
    check(sb_q.size() == 0, "R2 pass after saturation", sb_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule